// File: doc/BRIEF.md
# Transmit Gap Pacer with Carrier Monitor

This block paces a 10/100 Ethernet transmitter. After each frame it holds the next frame back for a programmable minimum inter-frame gap. The gap is counted in bit times at the selected line speed. While a frame is in flight in half-duplex mode, it watches the carrier-sense input. At the end of the frame it reports two conditions: the carrier was never seen, or the carrier was seen and then dropped. It can also request that the frame be aborted as soon as the carrier drops.

The transmit datapath offers a frame on `tx_req_valid`, and the block answers with `tx_permit`, which acts as the ready signal. A frame starts on the cycle both are high. The datapath must hold `tx_req_valid` until it sees `tx_permit`; this is the only back-pressure on the interface. The datapath marks the end of the frame with a one-cycle `tx_done`.

The gap is measured with a nibble-rate strobe derived from the core clock. The strobe fires every `DIV_SLOW` core cycles at 10 Mbps and every `DIV_FAST` core cycles at 100 Mbps. Each strobe stands for 4 bit times.

Top module: `mac_tx_pacer`

## Requirements
- R1: While reset is held and just after it is released, `tx_permit` is 1 and `err_no_crs`, `err_crs_lost` and `tx_abort` are 0.
- R2: A frame starts on a clock edge where `tx_req_valid` and `tx_permit` are both 1, and `tx_permit` is 0 from the next cycle until the gap after that frame has ended. A `tx_done` received while no frame is in flight has no effect.
- R3: The gap length is 96 − 8·`cfg_gap_code` bit times, which is (96 − 8·code)/4 strobes. `tx_permit` goes high right after the edge that comes exactly strobes × divider core cycles after the edge that sampled `tx_done`. The code is read at that same edge.
- R4: When `cfg_speed_100`=1 the divider is `DIV_FAST` (default 4, 100 Mbps). When it is 0 the divider is `DIV_SLOW` (default 40, 10 Mbps). The speed is read at the `tx_done` edge.
- R5: When `cfg_half_duplex`=1, codes 5, 6 and 7 give the gap of code 4 (64 bit times), and codes 0 to 4 keep their own values. In full duplex all eight codes apply unchanged.
- R6: In a half-duplex frame with checking on (`cfg_crs_ignore`=0), `err_no_crs` pulses if `crs` was high in no cycle of the frame, counting the `tx_done` cycle.
- R7: In such a frame, `err_crs_lost` pulses if `crs` was high and later low in some cycle before the `tx_done` cycle. A drop that happens only in the `tx_done` cycle is not reported.
- R8: With `cfg_crs_ignore`=1, or in full duplex, no error flag and no abort is produced. The checking mode is taken when the frame starts.
- R9: `tx_abort` is a one-cycle pulse in the cycle after the first carrier drop that R7 counts. It occurs only if `cfg_abort_en`=1 in the cycle of the drop.
- R10: The error flags are one-cycle pulses in the cycle right after the edge that sampled `tx_done`, and at most one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gap_code | input | 3 | Gap code, 96 − 8·code bit times |
| cfg_speed_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| cfg_half_duplex | input | 1 | 1 = half duplex |
| cfg_crs_ignore | input | 1 | 1 = disable carrier checking |
| cfg_abort_en | input | 1 | Allow abort on carrier loss |
| tx_req_valid | input | 1 | Datapath offers a frame |
| tx_permit | output | 1 | Ready: a frame may start |
| tx_done | input | 1 | Last cycle of the frame |
| crs | input | 1 | Carrier sense |
| err_no_crs | output | 1 | Pulse: carrier never seen |
| err_crs_lost | output | 1 | Pulse: carrier lost mid-frame |
| tx_abort | output | 1 | Pulse: abort the current frame |

## Verification
Two things can happen in the same cycle: the end of a frame and a change on the carrier. Directed frames place a carrier drop exactly on the `tx_done` cycle, which must yield no loss report. Other directed frames show the carrier for the first time on the `tx_done` cycle, which must count as seen and give no no-carrier report. Random frames mix codes, speeds, duplex modes, carrier patterns and abort enables. Each one is checked for the gap length to the exact cycle, the error pulses and the abort count, all against values that bench functions compute from the requirements.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_GAP  = 2'd2
  } mtp_state_e;
endpackage

// File: rtl/mtp_code_map.sv
// Turns the gap code into a strobe count, clamping in half duplex.
module mtp_code_map #(
  parameter int CODE_W       = 3,
  parameter int BASE_BITS    = 96,
  parameter int STEP_BITS    = 8,
  parameter int BITS_PER_STB = 4,
  parameter int HD_MAX_CODE  = 4,
  parameter int CNT_W        = 5
) (
  input  logic [CODE_W-1:0] code,
  input  logic              half_duplex,
  output logic [CNT_W-1:0]  gap_strobes
);
  logic [CODE_W-1:0] eff_code;

  always_comb begin
    eff_code = code;
    if (half_duplex && (code > CODE_W'(HD_MAX_CODE)))
      eff_code = CODE_W'(HD_MAX_CODE);
    gap_strobes = CNT_W'((BASE_BITS - STEP_BITS * int'(eff_code)) / BITS_PER_STB);
  end
endmodule

// File: rtl/mtp_gap_timer.sv
// Restarts the nibble divider on start and counts strobes up to the target.
module mtp_gap_timer #(
  parameter int DIV_SLOW = 40,
  parameter int DIV_FAST = 4,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             speed_fast,
  input  logic [CNT_W-1:0] target,
  output logic             elapsed
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int DIV_W   = $clog2(DIV_MAX + 1);

  logic             run_q;
  logic [DIV_W-1:0] div_lim_q;
  logic [DIV_W-1:0] div_cnt_q;
  logic [CNT_W-1:0] stb_cnt_q;
  logic [CNT_W-1:0] tgt_q;
  logic             tick;

  assign tick    = run_q && (div_cnt_q == (div_lim_q - 1'b1));
  assign elapsed = tick && (stb_cnt_q == (tgt_q - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      div_lim_q <= DIV_W'(DIV_SLOW);
      div_cnt_q <= '0;
      stb_cnt_q <= '0;
      tgt_q     <= '0;
    end else if (start) begin
      run_q     <= 1'b1;
      div_lim_q <= speed_fast ? DIV_W'(DIV_FAST) : DIV_W'(DIV_SLOW);
      div_cnt_q <= '0;
      stb_cnt_q <= '0;
      tgt_q     <= target;
    end else if (run_q) begin
      if (tick) begin
        div_cnt_q <= '0;
        if (elapsed) run_q <= 1'b0;
        else         stb_cnt_q <= stb_cnt_q + 1'b1;
      end else begin
        div_cnt_q <= div_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mtp_crs_monitor.sv
// Tracks carrier sense across one frame; reports at the end, aborts on loss.
module mtp_crs_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic in_frame,
  input  logic frame_end,
  input  logic check_en,
  input  logic abort_en,
  input  logic crs,
  output logic err_no_crs,
  output logic err_lost,
  output logic abort
);
  logic chk_q, seen_q, lost_q;
  logic body;

  assign body = in_frame && !frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q  <= 1'b0;
      seen_q <= 1'b0;
      lost_q <= 1'b0;
    end else if (frame_start) begin
      chk_q  <= check_en;
      seen_q <= 1'b0;
      lost_q <= 1'b0;
    end else if (body) begin
      if (crs)            seen_q <= 1'b1;
      if (seen_q && !crs) lost_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_no_crs <= 1'b0;
      err_lost   <= 1'b0;
      abort      <= 1'b0;
    end else begin
      err_no_crs <= frame_end && chk_q && !(seen_q || crs);
      err_lost   <= frame_end && chk_q && lost_q;
      abort      <= body && chk_q && abort_en && seen_q && !crs && !lost_q;
    end
  end
endmodule

// File: rtl/mac_tx_pacer.sv
module mac_tx_pacer #(
  parameter int CODE_W       = 3,
  parameter int DIV_SLOW     = 40,
  parameter int DIV_FAST     = 4,
  parameter int BASE_BITS    = 96,
  parameter int STEP_BITS    = 8,
  parameter int BITS_PER_STB = 4,
  parameter int HD_MAX_CODE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] cfg_gap_code,
  input  logic              cfg_speed_100,
  input  logic              cfg_half_duplex,
  input  logic              cfg_crs_ignore,
  input  logic              cfg_abort_en,
  input  logic              tx_req_valid,
  output logic              tx_permit,
  input  logic              tx_done,
  input  logic              crs,
  output logic              err_no_crs,
  output logic              err_crs_lost,
  output logic              tx_abort
);
  import mtp_pkg::*;

  localparam int CNT_W = $clog2(BASE_BITS / BITS_PER_STB + 1);

  mtp_state_e       st_q, st_d;
  logic             accept, done_acc, gap_elapsed;
  logic [CNT_W-1:0] gap_strobes;

  assign tx_permit = (st_q == ST_IDLE);
  assign accept    = tx_req_valid && tx_permit;
  assign done_acc  = tx_done && (st_q == ST_BUSY);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept)      st_d = ST_BUSY;
      ST_BUSY: if (tx_done)     st_d = ST_GAP;
      ST_GAP:  if (gap_elapsed) st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  mtp_code_map #(
    .CODE_W(CODE_W), .BASE_BITS(BASE_BITS), .STEP_BITS(STEP_BITS),
    .BITS_PER_STB(BITS_PER_STB), .HD_MAX_CODE(HD_MAX_CODE), .CNT_W(CNT_W)
  ) u_map (
    .code(cfg_gap_code),
    .half_duplex(cfg_half_duplex),
    .gap_strobes(gap_strobes)
  );

  mtp_gap_timer #(
    .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk),
    .rst_n(rst_n),
    .start(done_acc),
    .speed_fast(cfg_speed_100),
    .target(gap_strobes),
    .elapsed(gap_elapsed)
  );

  mtp_crs_monitor u_crs (
    .clk(clk),
    .rst_n(rst_n),
    .frame_start(accept),
    .in_frame(st_q == ST_BUSY),
    .frame_end(done_acc),
    .check_en(cfg_half_duplex && !cfg_crs_ignore),
    .abort_en(cfg_abort_en),
    .crs(crs),
    .err_no_crs(err_no_crs),
    .err_lost(err_crs_lost),
    .abort(tx_abort)
  );
endmodule

// File: rtl/mac_tx_pacer_chk.sv
module mac_tx_pacer_chk #(
  parameter int CODE_W       = 3,
  parameter int DIV_SLOW     = 40,
  parameter int DIV_FAST     = 4,
  parameter int BASE_BITS    = 96,
  parameter int STEP_BITS    = 8,
  parameter int BITS_PER_STB = 4
) (
  input logic clk,
  input logic rst_n,
  input logic tx_req_valid,
  input logic tx_done,
  input logic cfg_abort_en,
  input logic tx_permit,
  input logic err_no_crs,
  input logic err_crs_lost,
  input logic tx_abort,
  input logic in_frame
);
  localparam int DIV_MIN = (DIV_SLOW < DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int MIN_T   = ((BASE_BITS - STEP_BITS * ((1 << CODE_W) - 1)) / BITS_PER_STB) * DIV_MIN;

  logic [15:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    gap_cnt <= '0;
    else if (tx_done && in_frame)  gap_cnt <= '0;
    else if (gap_cnt < 16'(MIN_T)) gap_cnt <= gap_cnt + 1'b1;
  end

  a_r2_permit_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_valid && tx_permit) |=> !tx_permit);

  a_r3_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_permit) |-> (gap_cnt >= 16'(MIN_T)));

  a_r10_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_no_crs && err_crs_lost));

  a_r10_flag_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (err_no_crs || err_crs_lost) |-> $past(tx_done));

  a_r10_flag_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (err_no_crs || err_crs_lost) |=> !(err_no_crs || err_crs_lost));

  a_r9_abort_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> $past(cfg_abort_en));

  a_r9_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !tx_abort);
endmodule

bind mac_tx_pacer mac_tx_pacer_chk #(
  .CODE_W(CODE_W), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST),
  .BASE_BITS(BASE_BITS), .STEP_BITS(STEP_BITS), .BITS_PER_STB(BITS_PER_STB)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .tx_req_valid(tx_req_valid),
  .tx_done(tx_done),
  .cfg_abort_en(cfg_abort_en),
  .tx_permit(tx_permit),
  .err_no_crs(err_no_crs),
  .err_crs_lost(err_crs_lost),
  .tx_abort(tx_abort),
  .in_frame(st_q == mtp_pkg::ST_BUSY)
);

// File: tb/mac_tx_pacer_tb.sv
module mac_tx_pacer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_gap_code = '0;
  logic       cfg_speed_100 = 1'b0, cfg_half_duplex = 1'b0, cfg_crs_ignore = 1'b0;
  logic       cfg_abort_en = 1'b0, tx_req_valid = 1'b0, tx_done = 1'b0, crs = 1'b0;
  logic       tx_permit, err_no_crs, err_crs_lost, tx_abort;
  int         n_cmp = 0, n_bad = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  mac_tx_pacer u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_strobes(input int code, input bit hd);
    int c = (hd && code > 4) ? 4 : code;
    return (96 - 8 * c) / 4;
  endfunction

  function automatic int exp_div(input bit fast);
    return fast ? 4 : 40;
  endfunction

  // pat: 0 never, 1 always, 2 drop after k body cycles, 3 drop on done only, 4 first seen on done
  function automatic bit crs_at(input int pat, input int i, input int k, input bit on_done);
    case (pat)
      1: return 1'b1;
      2: return on_done ? 1'b0 : (i < k);
      3: return !on_done;
      4: return on_done;
      default: return 1'b0;
    endcase
  endfunction

  task automatic frame(input int code, input bit fast, input bit hd, input bit ign,
                       input bit aen, input int pat, input int len, input int k);
    int aborts = 0;
    int t;
    bit chk = hd && !ign;
    string gtag = (hd && code > 4) ? "R5" : (fast ? "R3" : "R4");
    cfg_gap_code = 3'(code); cfg_speed_100 = fast; cfg_half_duplex = hd;
    cfg_crs_ignore = ign; cfg_abort_en = aen;
    while (!tx_permit) @(negedge clk);
    tx_req_valid = 1'b1;
    @(negedge clk);
    tx_req_valid = 1'b0;
    check("R2 permit low in frame", tx_permit, 0);
    for (int i = 0; i < len; i++) begin
      crs = crs_at(pat, i, k, 1'b0);
      @(negedge clk);
      if (tx_abort) aborts++;
    end
    tx_done = 1'b1;
    crs = crs_at(pat, len, k, 1'b1);
    @(negedge clk);
    tx_done = 1'b0; crs = 1'b0;
    if (tx_abort) aborts++;
    check("R6 no-carrier flag", err_no_crs, int'(chk && pat == 0));
    check("R7 carrier-lost flag", err_crs_lost, int'(chk && pat == 2));
    check("R9 abort count", aborts, int'(chk && aen && pat == 2));
    @(negedge clk);
    check("R10 flags single cycle", int'(err_no_crs || err_crs_lost), 0);
    t = 1;
    while (!tx_permit && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check({gtag, " gap cycles"}, t, exp_strobes(code, hd) * exp_div(fast));
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check("R1 permit in reset", tx_permit, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 permit after reset", tx_permit, 1);
    check("R1 flags after reset", int'(err_no_crs || err_crs_lost || tx_abort), 0);

    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    @(negedge clk);
    check("R2 idle done ignored", tx_permit, 1);

    frame(0, 1'b0, 1'b0, 1'b0, 1'b0, 1, 8, 0);   // R4 slow, code 0
    frame(7, 1'b1, 1'b0, 1'b0, 1'b0, 0, 6, 0);   // R3 code 7 full duplex, R8 quiet
    frame(7, 1'b1, 1'b1, 1'b0, 1'b0, 1, 6, 0);   // R5 clamp
    frame(3, 1'b1, 1'b1, 1'b0, 1'b0, 1, 6, 0);   // R5 low code kept
    frame(4, 1'b1, 1'b1, 1'b0, 1'b0, 0, 6, 0);   // R6 no carrier
    frame(2, 1'b1, 1'b1, 1'b0, 1'b1, 2, 9, 3);   // R7 + R9 abort
    frame(2, 1'b1, 1'b1, 1'b0, 1'b0, 2, 9, 8);   // R9 disabled, drop on last body cycle
    frame(5, 1'b1, 1'b1, 1'b0, 1'b1, 3, 7, 0);   // R7 drop on done cycle only
    frame(6, 1'b1, 1'b1, 1'b0, 1'b0, 4, 7, 0);   // R6 carrier first on done cycle
    frame(1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 5, 0);   // R8 ignore
    frame(6, 1'b0, 1'b1, 1'b0, 1'b0, 1, 5, 0);   // R4 + R5 slow clamp

    for (int n = 0; n < 30; n++) begin
      int len = 2 + int'($urandom_range(10));
      frame(int'($urandom_range(7)), ($urandom_range(3) != 0), 1'($urandom_range(1)),
            ($urandom_range(3) == 0), 1'($urandom_range(1)), int'($urandom_range(4)),
            len, 1 + int'($urandom_range(len - 2)));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule